// File: doc/BRIEF.md
# Block-Transfer Host Mailbox Register File

This block is the host-facing side of a block-transfer management mailbox. The host sees a small byte-wide window with three registers: a control/status byte, a data port and an interrupt mask byte. Through the data port the host writes a request into a request buffer and reads a response out of a response buffer. Both buffers keep their own byte index.

Request handling happens in a separate controller. When the host raises attention in the control register, the block marks the controller busy and sends a one-cycle request-ready pulse. The controller then reads the request bytes through a side read port. Later it fills the response buffer and commits it with a load strobe.

The controller also reports a side-channel attention event, which may raise the host interrupt. A cold reset strobe drops the interrupt enable. The host interrupt is a level signal that a global allow input can gate.

Top module: `bt_mbox_regs`

## Requirements
- R1: After the asynchronous reset, control reads 0x00, mask reads 0x00, `irq_o` is low, `req_len_o` is 0 and `rdata_o` is 0x00.
- R2: The register offset is the address ANDed with `WIN_BYTES-1`. Offset 0 is control, 1 is data and 2 is mask. Any other offset reads 0xFF and ignores writes, so aliases such as address 5 reach the data port.
- R3: Control byte layout:
  - bit0 clear-write-index, write 1 to act
  - bit1 clear-read-index, write 1 to act
  - bit2 host attention, write 1 to act
  - bit3 controller-to-host attention
  - bit4 side attention
  - bit6 host busy
  - bit7 controller busy

  Writing 1 to bit3 or bit4 clears that flag. Writing 1 to bit6 toggles host busy. Writing 1 to bit2 sets controller busy, and `req_ready_o` is high for exactly the one cycle after the write. Bits 0, 1, 2 and 5 always read 0.
- R4: A data write stores the byte at the write index only while the index is below `IN_DEPTH`. The index still increments, saturating at all ones. `req_len_o` shows the index, and `req_rdata_o` returns the stored byte at `req_raddr_i`.
- R5: A data read returns the response byte at the read index and advances the index. When the index reaches the response length, both index and length become 0. A read with nothing pending returns 0xFF. Read data appears on `rdata_o` in the cycle after the read strobe.
- R6: Mask byte layout: bit0 is enable and bit1 is pending. Writing enable 0→1 while controller-to-host or side attention is set makes pending 1. Writing enable 1→0 clears pending. After that, a 1 in bit1 clears pending. Pending is never set while enable is clear.
- R7: `rsp_load_i` sets the response length to `rsp_len_i` (limited to `OUT_DEPTH`) and zeroes the read index. It clears controller busy and sets controller-to-host attention. If enable is set, it sets pending.
- R8: `sms_upd_i` with `sms_val_i` equal to the side attention flag has no effect. A change to 1 sets the flag, and also sets pending when `sms_irq_i` is high, controller-to-host attention is clear and enable is set. A change to 0 clears the flag, and also clears pending when controller-to-host attention is clear.
- R9: `cold_rst_i` clears enable and pending and leaves the control byte unchanged.
- R10: `irq_o` is high exactly when pending is set and `irq_allow_i` is high.
- R11: Events in one cycle apply in this order: host register write, then response load, then side attention update, then cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Host byte address |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Host read strobe |
| rdata_o | output | 8 | Registered host read data |
| irq_o | output | 1 | Level interrupt to host |
| irq_allow_i | input | 1 | Global interrupt allow |
| req_ready_o | output | 1 | One-cycle request-ready pulse |
| req_len_o | output | WIDX_W | Request write index (byte count) |
| req_raddr_i | input | IN_AW | Controller read address into request buffer |
| req_rdata_o | output | 8 | Request byte at req_raddr_i |
| rsp_wr_i | input | 1 | Controller response-buffer write strobe |
| rsp_waddr_i | input | OUT_AW | Response-buffer write address |
| rsp_wdata_i | input | 8 | Response-buffer write data |
| rsp_load_i | input | 1 | Commit response of length rsp_len_i |
| rsp_len_i | input | LEN_W | Response length |
| sms_upd_i | input | 1 | Side attention update strobe |
| sms_val_i | input | 1 | New side attention value |
| sms_irq_i | input | 1 | Side attention may raise the interrupt |
| cold_rst_i | input | 1 | Cold reset strobe |

## Verification
The hardest state to reach is an ignored side-attention update while pending is clear. To get there, the stimulus first raises side attention, then clears pending through the mask, then repeats the same value; pending must stay low. A similar route covers the write-index saturation. The stimulus writes well past the request buffer capacity, and the bench checks that the first bytes survive and the count stops at all ones. The collision of a response load with a cold reset in the same cycle is driven directly, so the ordering rule is seen at the mask register.

// File: rtl/bt_mbox_pkg.sv
package bt_mbox_pkg;
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_DATA = 1;
  localparam int unsigned OFF_MASK = 2;

  // control byte bit positions (host software decodes these)
  localparam int unsigned CB_CLR_WR = 0;
  localparam int unsigned CB_CLR_RD = 1;
  localparam int unsigned CB_H2B    = 2;
  localparam int unsigned CB_B2H    = 3;
  localparam int unsigned CB_SMS    = 4;
  localparam int unsigned CB_HBUSY  = 6;
  localparam int unsigned CB_BBUSY  = 7;

  // mask byte bit positions
  localparam int unsigned MB_EN   = 0;
  localparam int unsigned MB_PEND = 1;

  typedef enum logic [1:0] {SEL_CTRL, SEL_DATA, SEL_MASK, SEL_NONE} reg_sel_e;

  typedef struct packed {
    logic bbusy;
    logic hbusy;
    logic sms;
    logic b2h;
  } flag_t;
endpackage

// File: rtl/bt_req_buf.sv
module bt_req_buf #(
  parameter int unsigned IN_DEPTH = 32,
  localparam int unsigned IN_AW   = $clog2(IN_DEPTH),
  localparam int unsigned WIDX_W  = $clog2(IN_DEPTH + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [7:0]        wdata_i,
  input  logic [IN_AW-1:0]  raddr_i,
  output logic [7:0]        rdata_o,
  output logic [WIDX_W-1:0] len_o
);
  localparam logic [WIDX_W-1:0] CAP = WIDX_W'(IN_DEPTH);

  logic [7:0]        mem [IN_DEPTH];
  logic [WIDX_W-1:0] widx_q;
  logic              in_range;

  assign in_range = widx_q < CAP;

  always_ff @(posedge clk_i) begin
    if (wr_i && in_range) mem[widx_q[IN_AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  widx_q <= '0;
    else if (clr_i)               widx_q <= '0;
    else if (wr_i && ~&widx_q)    widx_q <= widx_q + WIDX_W'(1);
  end

  assign rdata_o = mem[raddr_i];
  assign len_o   = widx_q;
endmodule

// File: rtl/bt_rsp_buf.sv
module bt_rsp_buf #(
  parameter int unsigned OUT_DEPTH = 32,
  localparam int unsigned OUT_AW   = $clog2(OUT_DEPTH),
  localparam int unsigned LEN_W    = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_wr_i,
  input  logic [OUT_AW-1:0] fill_addr_i,
  input  logic [7:0]        fill_data_i,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              rd_i,
  input  logic              clr_rd_i,
  output logic [7:0]        byte_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(OUT_DEPTH);

  logic [7:0]       mem [OUT_DEPTH];
  logic [LEN_W-1:0] ridx_q, len_q, ridx_inc;
  logic             avail;

  assign avail    = ridx_q < len_q;
  assign ridx_inc = ridx_q + LEN_W'(1);
  assign byte_o   = avail ? mem[ridx_q[OUT_AW-1:0]] : 8'hFF;
  assign len_o    = len_q;

  always_ff @(posedge clk_i) begin
    if (fill_wr_i) mem[fill_addr_i] <= fill_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q <= '0;
      len_q  <= '0;
    end else if (load_i) begin
      ridx_q <= '0;
      len_q  <= (load_len_i > CAP) ? CAP : load_len_i;
    end else if (clr_rd_i) begin
      ridx_q <= '0;
    end else if (rd_i && avail) begin
      if (ridx_inc == len_q) begin
        ridx_q <= '0;
        len_q  <= '0;
      end else begin
        ridx_q <= ridx_inc;
      end
    end
  end
endmodule

// File: rtl/bt_ctrl_irq.sv
module bt_ctrl_irq
  import bt_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic       mask_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       load_i,
  input  logic       sms_upd_i,
  input  logic       sms_val_i,
  input  logic       sms_irq_i,
  input  logic       cold_rst_i,
  output logic [7:0] ctrl_byte_o,
  output logic [7:0] mask_byte_o,
  output logic       req_pulse_o,
  output logic       b2h_o,
  output logic       bbusy_o,
  output logic       en_o,
  output logic       pend_o
);
  flag_t flg_q, flg_d;
  logic  en_q, en_d, pend_q, pend_d, req_q;
  logic  unused_bits;

  assign unused_bits = ^{wdata_i[CB_CLR_WR], wdata_i[CB_CLR_RD], wdata_i[5]};

  // ordering: host write, response load, side attention, cold reset
  always_comb begin
    flg_d  = flg_q;
    en_d   = en_q;
    pend_d = pend_q;
    if (ctrl_wr_i) begin
      if (wdata_i[CB_B2H])   flg_d.b2h   = 1'b0;
      if (wdata_i[CB_SMS])   flg_d.sms   = 1'b0;
      if (wdata_i[CB_HBUSY]) flg_d.hbusy = ~flg_q.hbusy;
      if (wdata_i[CB_H2B])   flg_d.bbusy = 1'b1;
    end
    if (mask_wr_i) begin
      if (wdata_i[MB_EN] != en_q) begin
        if (wdata_i[MB_EN]) begin
          if (flg_d.b2h || flg_d.sms) pend_d = 1'b1;
          en_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          en_d   = 1'b0;
        end
      end
      if (wdata_i[MB_PEND] && pend_d) pend_d = 1'b0;
    end
    if (load_i) begin
      flg_d.bbusy = 1'b0;
      flg_d.b2h   = 1'b1;
      if (!pend_d && en_d) pend_d = 1'b1;
    end
    if (sms_upd_i && (sms_val_i != flg_d.sms)) begin
      flg_d.sms = sms_val_i;
      if (sms_val_i) begin
        if (sms_irq_i && !flg_d.b2h && en_d) pend_d = 1'b1;
      end else if (!flg_d.b2h && pend_d) begin
        pend_d = 1'b0;
      end
    end
    if (cold_rst_i) begin
      pend_d = 1'b0;
      en_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      flg_q  <= flg_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      req_q  <= ctrl_wr_i && wdata_i[CB_H2B];
    end
  end

  always_comb begin
    ctrl_byte_o            = '0;
    ctrl_byte_o[CB_B2H]    = flg_q.b2h;
    ctrl_byte_o[CB_SMS]    = flg_q.sms;
    ctrl_byte_o[CB_HBUSY]  = flg_q.hbusy;
    ctrl_byte_o[CB_BBUSY]  = flg_q.bbusy;
    mask_byte_o            = '0;
    mask_byte_o[MB_EN]     = en_q;
    mask_byte_o[MB_PEND]   = pend_q;
  end

  assign req_pulse_o = req_q;
  assign b2h_o       = flg_q.b2h;
  assign bbusy_o     = flg_q.bbusy;
  assign en_o        = en_q;
  assign pend_o      = pend_q;
endmodule

// File: rtl/bt_mbox_regs.sv
module bt_mbox_regs
  import bt_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WIN_BYTES = 4,
  parameter int unsigned IN_DEPTH  = 32,
  parameter int unsigned OUT_DEPTH = 32,
  localparam int unsigned IN_AW    = $clog2(IN_DEPTH),
  localparam int unsigned OUT_AW   = $clog2(OUT_DEPTH),
  localparam int unsigned WIDX_W   = $clog2(IN_DEPTH + 1) + 1,
  localparam int unsigned LEN_W    = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              irq_allow_i,
  output logic              req_ready_o,
  output logic [WIDX_W-1:0] req_len_o,
  input  logic [IN_AW-1:0]  req_raddr_i,
  output logic [7:0]        req_rdata_o,
  input  logic              rsp_wr_i,
  input  logic [OUT_AW-1:0] rsp_waddr_i,
  input  logic [7:0]        rsp_wdata_i,
  input  logic              rsp_load_i,
  input  logic [LEN_W-1:0]  rsp_len_i,
  input  logic              sms_upd_i,
  input  logic              sms_val_i,
  input  logic              sms_irq_i,
  input  logic              cold_rst_i
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(WIN_BYTES - 1);

  reg_sel_e          sel;
  logic [ADDR_W-1:0] off;
  logic              ctrl_wr, data_wr, mask_wr, data_rd;
  logic [7:0]        ctrl_byte, mask_byte, rsp_byte, rdata_q;
  logic              b2h, bbusy, irq_en, irq_pend;
  logic [LEN_W-1:0]  rsp_len_cur;

  assign off = addr_i & WIN_MASK;

  always_comb begin
    if      (off == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    else if (off == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
    else if (off == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else                               sel = SEL_NONE;
  end

  assign ctrl_wr = wr_i && (sel == SEL_CTRL);
  assign data_wr = wr_i && (sel == SEL_DATA);
  assign mask_wr = wr_i && (sel == SEL_MASK);
  assign data_rd = rd_i && (sel == SEL_DATA);

  bt_req_buf #(.IN_DEPTH(IN_DEPTH)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (data_wr),
    .clr_i   (ctrl_wr && wdata_i[CB_CLR_WR]),
    .wdata_i (wdata_i),
    .raddr_i (req_raddr_i),
    .rdata_o (req_rdata_o),
    .len_o   (req_len_o)
  );

  bt_rsp_buf #(.OUT_DEPTH(OUT_DEPTH)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_wr_i   (rsp_wr_i),
    .fill_addr_i (rsp_waddr_i),
    .fill_data_i (rsp_wdata_i),
    .load_i      (rsp_load_i),
    .load_len_i  (rsp_len_i),
    .rd_i        (data_rd),
    .clr_rd_i    (ctrl_wr && wdata_i[CB_CLR_RD]),
    .byte_o      (rsp_byte),
    .len_o       (rsp_len_cur)
  );

  bt_ctrl_irq u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .mask_wr_i   (mask_wr),
    .wdata_i     (wdata_i),
    .load_i      (rsp_load_i),
    .sms_upd_i   (sms_upd_i),
    .sms_val_i   (sms_val_i),
    .sms_irq_i   (sms_irq_i),
    .cold_rst_i  (cold_rst_i),
    .ctrl_byte_o (ctrl_byte),
    .mask_byte_o (mask_byte),
    .req_pulse_o (req_ready_o),
    .b2h_o       (b2h),
    .bbusy_o     (bbusy),
    .en_o        (irq_en),
    .pend_o      (irq_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      unique case (sel)
        SEL_CTRL: rdata_q <= ctrl_byte;
        SEL_DATA: rdata_q <= rsp_byte;
        SEL_MASK: rdata_q <= mask_byte;
        default:  rdata_q <= 8'hFF;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_pend && irq_allow_i;
endmodule

// File: rtl/bt_mbox_chk.sv
module bt_mbox_chk
  import bt_mbox_pkg::*;
#(
  parameter int unsigned WIDX_W = 7,
  parameter int unsigned LEN_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input reg_sel_e          sel_i,
  input logic [7:0]        wdata_i,
  input logic              rsp_load_i,
  input logic              cold_rst_i,
  input logic              req_ready_o,
  input logic [7:0]        rdata_o,
  input logic [WIDX_W-1:0] widx_i,
  input logic [LEN_W-1:0]  cur_len_i,
  input logic              b2h_i,
  input logic              bbusy_i,
  input logic              en_i,
  input logic              pend_i
);
  a_r3_h2b_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_CTRL && wdata_i[CB_H2B]) |=> req_ready_o);

  a_r3_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_CTRL && wdata_i[CB_H2B] && !rsp_load_i) |=> bbusy_i);

  a_r4_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_DATA && ~&widx_i) |=> (widx_i - $past(widx_i)) == WIDX_W'(1));

  a_r5_empty_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_DATA && cur_len_i == '0) |=> rdata_o == 8'hFF);

  a_r6_pend_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> en_i);

  a_r7_load_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> (b2h_i && !bbusy_i));

  a_r9_cold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> (!pend_i && !en_i));
endmodule

bind bt_mbox_regs bt_mbox_chk #(.WIDX_W(WIDX_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .sel_i       (sel),
  .wdata_i     (wdata_i),
  .rsp_load_i  (rsp_load_i),
  .cold_rst_i  (cold_rst_i),
  .req_ready_o (req_ready_o),
  .rdata_o     (rdata_o),
  .widx_i      (req_len_o),
  .cur_len_i   (rsp_len_cur),
  .b2h_i       (b2h),
  .bbusy_i     (bbusy),
  .en_i        (irq_en),
  .pend_i      (irq_pend)
);

// File: tb/bt_mbox_regs_tb.sv
`timescale 1ns/1ps
module bt_mbox_regs_tb;
  localparam int WIN = 4;
  localparam int IND = 32;
  localparam int OUTD = 32;
  localparam int WIDX_W = $clog2(IND + 1) + 1;
  localparam int LEN_W = $clog2(OUTD + 1);
  localparam int IN_AW = $clog2(IND);
  localparam int OUT_AW = $clog2(OUTD);
  localparam int SAT = (1 << WIDX_W) - 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr = 0, rd = 0, allow = 0;
  logic [7:0] rdata_o;
  logic irq_o, req_ready_o;
  logic [WIDX_W-1:0] req_len_o;
  logic [IN_AW-1:0] req_raddr = 0;
  logic [7:0] req_rdata_o;
  logic rsp_wr = 0, rsp_load = 0, sms_upd = 0, sms_val = 0, sms_irq = 0, cold = 0;
  logic [OUT_AW-1:0] rsp_waddr = 0;
  logic [7:0] rsp_wdata = 0;
  logic [LEN_W-1:0] rsp_len = 0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bt_mbox_regs #(.ADDR_W(8), .WIN_BYTES(WIN), .IN_DEPTH(IND), .OUT_DEPTH(OUTD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata_o), .irq_o(irq_o), .irq_allow_i(allow), .req_ready_o(req_ready_o),
    .req_len_o(req_len_o), .req_raddr_i(req_raddr), .req_rdata_o(req_rdata_o),
    .rsp_wr_i(rsp_wr), .rsp_waddr_i(rsp_waddr), .rsp_wdata_i(rsp_wdata),
    .rsp_load_i(rsp_load), .rsp_len_i(rsp_len), .sms_upd_i(sms_upd), .sms_val_i(sms_val),
    .sms_irq_i(sms_irq), .cold_rst_i(cold));

  // behavioural reference model
  bit m_b2h, m_sms, m_hbusy, m_bbusy, m_en, m_pend, m_rq;
  int m_widx, m_len, m_ridx, moff;
  byte unsigned m_out[OUTD];
  byte unsigned m_rdata;

  function automatic byte unsigned m_ctrl();
    return {m_bbusy, m_hbusy, 1'b0, m_sms, m_b2h, 3'b000};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_b2h, m_sms, m_hbusy, m_bbusy, m_en, m_pend, m_rq} = '0;
      m_widx = 0; m_len = 0; m_ridx = 0; m_rdata = 0;
    end else begin
      moff = addr % WIN;
      m_rq = 0;
      if (rd) begin
        if (moff == 0) m_rdata = m_ctrl();
        else if (moff == 2) m_rdata = {6'd0, m_pend, m_en};
        else if (moff == 1) begin
          if (m_ridx < m_len) begin
            m_rdata = m_out[m_ridx];
            m_ridx++;
            if (m_ridx == m_len) begin m_ridx = 0; m_len = 0; end
          end else m_rdata = 8'hFF;
        end else m_rdata = 8'hFF;
      end
      if (wr) begin
        if (moff == 0) begin
          if (wdata[0]) m_widx = 0;
          if (wdata[1]) m_ridx = 0;
          if (wdata[3]) m_b2h = 0;
          if (wdata[4]) m_sms = 0;
          if (wdata[6]) m_hbusy = !m_hbusy;
          if (wdata[2]) begin m_bbusy = 1; m_rq = 1; end
        end else if (moff == 1) begin
          if (m_widx < SAT) m_widx++;
        end else if (moff == 2) begin
          if (wdata[0] && !m_en) begin m_en = 1; if (m_b2h || m_sms) m_pend = 1; end
          else if (!wdata[0] && m_en) begin m_en = 0; m_pend = 0; end
          if (wdata[1]) m_pend = 0;
        end
      end
      if (rsp_wr) m_out[rsp_waddr] = rsp_wdata;
      if (rsp_load) begin
        m_len = (rsp_len > OUTD) ? OUTD : int'(rsp_len);
        m_ridx = 0; m_bbusy = 0; m_b2h = 1;
        if (m_en) m_pend = 1;
      end
      if (sms_upd && sms_val != m_sms) begin
        m_sms = sms_val;
        if (sms_val && sms_irq && !m_b2h && m_en) m_pend = 1;
        if (!sms_val && !m_b2h) m_pend = 0;
      end
      if (cold) begin m_pend = 0; m_en = 0; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " rdata"}, rdata_o, m_rdata);
      chk({cur_req, " irq R10"}, irq_o, m_pend && allow);
      chk({cur_req, " req_ready"}, req_ready_o, m_rq);
      chk({cur_req, " req_len"}, req_len_o, m_widx);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1; addr = a; wdata = d; wr = 1;
    @(negedge clk); #1; wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); #1; addr = a; rd = 1;
    @(negedge clk); #1; rd = 0; v = rdata_o;
  endtask

  task automatic rd_chk(string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  task automatic fill(input int a, input logic [7:0] d);
    @(negedge clk); #1; rsp_waddr = OUT_AW'(a); rsp_wdata = d; rsp_wr = 1;
    @(negedge clk); #1; rsp_wr = 0;
  endtask

  task automatic load(input int n, input bit with_cold);
    @(negedge clk); #1; rsp_len = LEN_W'(n); rsp_load = 1; cold = with_cold;
    @(negedge clk); #1; rsp_load = 0; cold = 0;
  endtask

  task automatic sms(input bit v, input bit q);
    @(negedge clk); #1; sms_val = v; sms_irq = q; sms_upd = 1;
    @(negedge clk); #1; sms_upd = 0;
  endtask

  task automatic req_peek(string req, input int a, input logic [7:0] exp);
    @(negedge clk); #1; req_raddr = IN_AW'(a);
    @(negedge clk); #1; chk(req, req_rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    rd_chk("R1 ctrl reset", 8'd0, 8'h00);
    rd_chk("R1 mask reset", 8'd2, 8'h00);
    chk("R1 irq reset", irq_o, 0);

    cur_req = "R2";
    rd_chk("R2 offset3 reads FF", 8'd3, 8'hFF);
    wr_reg(8'd3, 8'hFF);
    rd_chk("R2 offset3 write ignored", 8'd0, 8'h00);
    rd_chk("R2 alias offset3 FF", 8'd7, 8'hFF);
    wr_reg(8'd5, 8'hA5);
    chk("R2 alias data write", req_len_o, 1);
    req_peek("R2 alias data byte", 0, 8'hA5);

    cur_req = "R4";
    wr_reg(8'd0, 8'h01);
    chk("R3 clear write index", req_len_o, 0);
    for (int i = 0; i < 5; i++) wr_reg(8'd1, 8'h10 + 8'(i));
    chk("R4 len 5", req_len_o, 5);
    req_peek("R4 byte 2", 2, 8'h12);
    for (int i = 0; i < 29; i++) wr_reg(8'd1, 8'h20 + 8'(i));
    chk("R4 overrun len", req_len_o, 34);
    req_peek("R4 last stored byte", 31, 8'h3A);
    req_peek("R4 first byte kept", 0, 8'h10);
    for (int i = 0; i < 100; i++) wr_reg(8'd1, 8'h77);
    chk("R4 saturated", req_len_o, SAT);
    wr_reg(8'd0, 8'h01);

    cur_req = "R3";
    wr_reg(8'd0, 8'h04);
    chk("R3 request pulse", req_ready_o, 1);
    @(negedge clk); #1;
    chk("R3 pulse one cycle", req_ready_o, 0);
    rd_chk("R3 ctrl busy", 8'd0, 8'h80);
    wr_reg(8'd0, 8'h40);
    rd_chk("R3 hbusy on", 8'd0, 8'hC0);
    wr_reg(8'd0, 8'h40);
    rd_chk("R3 hbusy off", 8'd0, 8'h80);

    cur_req = "R7";
    fill(0, 8'hDE); fill(1, 8'hAD); fill(2, 8'hBE); fill(3, 8'hEF);
    load(4, 0);
    rd_chk("R7 ctrl after load", 8'd0, 8'h08);
    chk("R7 no irq when disabled", irq_o, 0);

    cur_req = "R5";
    rd_chk("R5 byte0", 8'd1, 8'hDE);
    rd_chk("R5 byte1", 8'd1, 8'hAD);
    rd_chk("R5 byte2", 8'd1, 8'hBE);
    rd_chk("R5 byte3", 8'd1, 8'hEF);
    rd_chk("R5 empty FF", 8'd1, 8'hFF);
    load(3, 0);
    rd_chk("R5 reload byte0", 8'd1, 8'hDE);
    wr_reg(8'd0, 8'h02);
    rd_chk("R3 clear read index", 8'd1, 8'hDE);
    rd_chk("R5 byte1 again", 8'd1, 8'hAD);
    rd_chk("R5 byte2 again", 8'd1, 8'hBE);
    rd_chk("R5 drained FF", 8'd1, 8'hFF);

    cur_req = "R6";
    allow = 1;
    wr_reg(8'd2, 8'h01);
    rd_chk("R6 enable with attention", 8'd2, 8'h03);
    chk("R10 irq high", irq_o, 1);
    @(negedge clk); #1 allow = 0;
    @(negedge clk); #1;
    chk("R10 irq gated", irq_o, 0);
    allow = 1;
    wr_reg(8'd2, 8'h03);
    rd_chk("R6 pending cleared by bit1", 8'd2, 8'h01);
    wr_reg(8'd2, 8'h00);
    rd_chk("R6 disable", 8'd2, 8'h00);
    wr_reg(8'd0, 8'h08);
    rd_chk("R3 b2h cleared", 8'd0, 8'h00);
    wr_reg(8'd2, 8'h01);
    rd_chk("R6 enable without attention", 8'd2, 8'h01);

    cur_req = "R8";
    sms(1, 1);
    rd_chk("R8 sms sets pending", 8'd2, 8'h03);
    rd_chk("R8 sms flag", 8'd0, 8'h10);
    wr_reg(8'd2, 8'h03);
    sms(1, 1);
    rd_chk("R8 same value ignored", 8'd2, 8'h01);
    wr_reg(8'd2, 8'h00);
    wr_reg(8'd2, 8'h01);
    rd_chk("R6 re-enable with sms", 8'd2, 8'h03);
    sms(0, 0);
    rd_chk("R8 drop clears pending", 8'd2, 8'h01);
    sms(1, 0);
    rd_chk("R8 no qualifier no pending", 8'd2, 8'h01);
    rd_chk("R8 flag set", 8'd0, 8'h10);

    cur_req = "R9";
    wr_reg(8'd2, 8'h00);
    wr_reg(8'd2, 8'h01);
    @(negedge clk); #1 cold = 1;
    @(negedge clk); #1 cold = 0;
    rd_chk("R9 cold clears mask", 8'd2, 8'h00);
    rd_chk("R9 ctrl untouched", 8'd0, 8'h10);

    cur_req = "R11";
    wr_reg(8'd2, 8'h01);
    load(2, 1);
    rd_chk("R11 cold after load", 8'd2, 8'h00);
    rd_chk("R11 load flags kept", 8'd0, 8'h18);
    chk("R11 irq low", irq_o, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule